// File: doc/BRIEF.md
# Reference-Loss Frequency Hold Controller

This block is the mode logic of a digital phase-locked loop. It decides whether the loop output tracks its live frequency word (Normal), freezes to a stored estimate (Holdover), or runs from a fixed ideal word derived only from the master clock (Freerun). The decision comes from a two-bit mode-select field, a loss flag for each of the two references, and a request input that forces Freerun.

While the loop runs in Normal mode and reports lock, the block takes a snapshot of the live frequency word once per storage period. The period is counted in millisecond ticks and is 32 ms by default. Snapshots go to two slots in turn. When Holdover begins, the block uses the slot that was *not* written most recently. The output therefore comes from an estimate between one and two periods old, which is past any disturbance just before the references failed. That word is held until the mode changes. The phase detector, loop filter and oscillator sit outside this block.

Top module: `dpll_mode_ctrl`

## Requirements
- R1: A synchronous reset puts `mode_state` at Freerun (encoding 2'b10) and `freq_out` at `NOMINAL_WORD`, and discards all snapshots. Normal is 2'b00 and Holdover is 2'b01.
- R2: With `mode_sel` = 2'b01, both loss flags high and no Freerun condition, the mode becomes Holdover after one clock edge.
- R3: With `mode_sel` = 2'b00, both loss flags high also give Holdover. `mode_sel` values 2'b10 and 2'b11, or only one loss flag high, never give Holdover.
- R4: In Holdover, `freerun_req` high moves the mode to Freerun at the next edge. Freerun is kept while `freerun_req` stays high or the Holdover condition persists. `freerun_req` has no effect in Normal.
- R5: From Holdover or Freerun, the mode returns to Normal at the next edge once the Holdover condition is gone and `freerun_req` is low. The encoding 2'b11 never appears.
- R6: While the next mode is Normal, `freq_out` equals the `freq_live` sampled at the previous edge.
- R7: A storage tick counter advances on `tick_ms` only while the mode stays Normal and `ref_lock` is high. Otherwise it clears. On the `PERIOD_MS`-th counted tick, `freq_live` is written into one of two slots, and the slots alternate.
- R8: On Holdover entry with both slots written, `freq_out` takes the value of the slot written second-to-last. It stays constant while Holdover lasts, whatever `freq_live` does.
- R9: On Holdover entry with fewer than two snapshots since reset, `freq_out` becomes `NOMINAL_WORD`.
- R10: In Freerun, `freq_out` is `NOMINAL_WORD` regardless of `freq_live`, lock or loss flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_sel | input | 2 | Mode-select field |
| pri_lost | input | 1 | Primary reference lost |
| sec_lost | input | 1 | Secondary reference lost |
| freerun_req | input | 1 | Request to force Freerun from Holdover |
| ref_lock | input | 1 | Loop locked flag |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| freq_live | input | FREQ_W | Live frequency word from the loop filter |
| freq_out | output | FREQ_W | Selected frequency word |
| mode_state | output | 2 | Current mode (00 Normal, 01 Holdover, 10 Freerun) |

## Verification
Every result is registered once. A change of mode inputs shows in `mode_state` one edge later, and `freq_out` follows on that same edge. A snapshot written on the edge of the `PERIOD_MS`-th tick can be seen only through a later Holdover entry. The bench drives inputs on the falling edge, advances its reference model on the rising edge, and compares both outputs on the next falling edge. Each expectation therefore sits exactly one register stage behind its stimulus.

// File: rtl/dpll_mode_pkg.sv
package dpll_mode_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL = 2'b00,
      MODE_HOLD   = 2'b01,
      MODE_FREE   = 2'b10
   } dpll_mode_e;
endpackage

// File: rtl/dpll_mode_fsm.sv
module dpll_mode_fsm
   import dpll_mode_pkg::*;
#(
   parameter bit AUTO_HOLD_EN = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic [1:0] mode_sel,
   input  logic       pri_lost,
   input  logic       sec_lost,
   input  logic       freerun_req,
   output dpll_mode_e mode_q,
   output dpll_mode_e mode_d
);
   logic manual_arm;
   logic auto_arm;
   logic hold_call;

   assign manual_arm = (mode_sel == 2'b01);

   generate
      if (AUTO_HOLD_EN) begin : g_auto
         assign auto_arm = (mode_sel == 2'b00);
      end else begin : g_no_auto
         assign auto_arm = 1'b0;
      end
   endgenerate

   assign hold_call = (manual_arm || auto_arm) && pri_lost && sec_lost;

   always_comb begin
      mode_d = mode_q;
      unique case (mode_q)
         MODE_NORMAL: mode_d = hold_call ? MODE_HOLD : MODE_NORMAL;
         MODE_HOLD: begin
            if (freerun_req)     mode_d = MODE_FREE;
            else if (!hold_call) mode_d = MODE_NORMAL;
         end
         MODE_FREE: begin
            if (!freerun_req && !hold_call) mode_d = MODE_NORMAL;
         end
         default: mode_d = MODE_FREE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) mode_q <= MODE_FREE;
      else     mode_q <= mode_d;
   end

   // R4: a freerun request during Holdover ends Holdover at the next edge
   p_hold_to_free_r4: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_HOLD && freerun_req) |=> (mode_q == MODE_FREE));

   // R3: a single lost reference never leads to Holdover
   p_single_loss_r3: assert property (@(posedge clk) disable iff (rst)
      !(pri_lost && sec_lost) |=> (mode_q != MODE_HOLD));

   // R5: the unused encoding is never reached
   p_legal_mode_r5: assert property (@(posedge clk) disable iff (rst)
      mode_q != 2'b11);
endmodule

// File: rtl/dpll_snap_store.sv
module dpll_snap_store #(
   parameter int FREQ_W    = 32,
   parameter int PERIOD_MS = 32
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              store_en,
   input  logic              tick,
   input  logic [FREQ_W-1:0] live,
   output logic [FREQ_W-1:0] older_word,
   output logic              older_ok
);
   localparam int CNT_W = $clog2(PERIOD_MS);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PERIOD_MS - 1);
   localparam int NSLOT = 2;

   logic [CNT_W-1:0]  tick_cnt;
   logic              wr_ptr;
   logic [1:0]        fill_cnt;
   logic              wr_strobe;
   logic [FREQ_W-1:0] slot_word [NSLOT];

   assign wr_strobe = store_en && tick && (tick_cnt == CNT_LAST);

   always_ff @(posedge clk) begin
      if (rst || !store_en) begin
         tick_cnt <= '0;
      end else if (tick) begin
         tick_cnt <= wr_strobe ? '0 : tick_cnt + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         wr_ptr   <= 1'b0;
         fill_cnt <= 2'd0;
      end else if (wr_strobe) begin
         wr_ptr <= ~wr_ptr;
         if (fill_cnt != 2'd2) fill_cnt <= fill_cnt + 2'd1;
      end
   end

   generate
      for (genvar g = 0; g < NSLOT; g++) begin : g_slot
         always_ff @(posedge clk) begin
            if (rst)                                 slot_word[g] <= '0;
            else if (wr_strobe && (wr_ptr == 1'(g))) slot_word[g] <= live;
         end

         // R7: a slot changes only on its own periodic write
         p_slot_hold_r7: assert property (@(posedge clk) disable iff (rst)
            !(wr_strobe && (wr_ptr == 1'(g))) |=> $stable(slot_word[g]));
      end
   endgenerate

   // the slot to be overwritten next holds the older snapshot
   assign older_word = slot_word[wr_ptr];
   assign older_ok   = (fill_cnt == 2'd2);

   // R7: the period counter stays inside its window
   p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
      tick_cnt <= CNT_LAST);

   // R7: counting is suspended outside locked Normal operation
   p_cnt_clear_r7: assert property (@(posedge clk) disable iff (rst)
      !store_en |=> (tick_cnt == '0));
endmodule

// File: rtl/dpll_freq_sel.sv
module dpll_freq_sel
   import dpll_mode_pkg::*;
#(
   parameter int                 FREQ_W       = 32,
   parameter logic [FREQ_W-1:0]  NOMINAL_WORD = '0
) (
   input  logic              clk,
   input  logic              rst,
   input  dpll_mode_e        mode_q,
   input  dpll_mode_e        mode_d,
   input  logic [FREQ_W-1:0] live,
   input  logic [FREQ_W-1:0] older_word,
   input  logic              older_ok,
   output logic [FREQ_W-1:0] freq_out
);
   logic [FREQ_W-1:0] freq_d;

   always_comb begin
      freq_d = freq_out;
      unique case (mode_d)
         MODE_NORMAL: freq_d = live;
         MODE_HOLD: begin
            if (mode_q != MODE_HOLD) freq_d = older_ok ? older_word : NOMINAL_WORD;
         end
         default: freq_d = NOMINAL_WORD;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) freq_out <= NOMINAL_WORD;
      else     freq_out <= freq_d;
   end

   // R8: the Holdover word is frozen while Holdover continues
   p_hold_frozen_r8: assert property (@(posedge clk) disable iff (rst)
      (mode_q == MODE_HOLD && mode_d == MODE_HOLD) |=> $stable(freq_out));

   // R10: Freerun always drives the ideal word
   p_free_nominal_r10: assert property (@(posedge clk) disable iff (rst)
      (mode_d == MODE_FREE) |=> (freq_out == NOMINAL_WORD));
endmodule

// File: rtl/dpll_mode_ctrl.sv
module dpll_mode_ctrl
   import dpll_mode_pkg::*;
#(
   parameter int                FREQ_W       = 32,
   parameter int                PERIOD_MS    = 32,
   parameter logic [FREQ_W-1:0] NOMINAL_WORD = FREQ_W'(32'h2000_0000),
   parameter bit                AUTO_HOLD_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [1:0]        mode_sel,
   input  logic              pri_lost,
   input  logic              sec_lost,
   input  logic              freerun_req,
   input  logic              ref_lock,
   input  logic              tick_ms,
   input  logic [FREQ_W-1:0] freq_live,
   output logic [FREQ_W-1:0] freq_out,
   output logic [1:0]        mode_state
);
   generate
      if (FREQ_W < 8) begin : g_bad_width
         $error("FREQ_W must be at least 8");
      end
      if (PERIOD_MS < 2) begin : g_bad_period
         $error("PERIOD_MS must be at least 2");
      end
   endgenerate

   dpll_mode_e        mode_q;
   dpll_mode_e        mode_d;
   logic              store_en;
   logic [FREQ_W-1:0] older_word;
   logic              older_ok;

   dpll_mode_fsm #(.AUTO_HOLD_EN(AUTO_HOLD_EN)) u_fsm (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .pri_lost(pri_lost),
      .sec_lost(sec_lost), .freerun_req(freerun_req),
      .mode_q(mode_q), .mode_d(mode_d)
   );

   // snapshots only while Normal persists across the edge and the loop is locked
   assign store_en = (mode_q == MODE_NORMAL) && (mode_d == MODE_NORMAL) && ref_lock;

   dpll_snap_store #(.FREQ_W(FREQ_W), .PERIOD_MS(PERIOD_MS)) u_store (
      .clk(clk), .rst(rst), .store_en(store_en), .tick(tick_ms),
      .live(freq_live), .older_word(older_word), .older_ok(older_ok)
   );

   dpll_freq_sel #(.FREQ_W(FREQ_W), .NOMINAL_WORD(NOMINAL_WORD)) u_sel (
      .clk(clk), .rst(rst), .mode_q(mode_q), .mode_d(mode_d),
      .live(freq_live), .older_word(older_word), .older_ok(older_ok),
      .freq_out(freq_out)
   );

   assign mode_state = mode_q;

   // R6: Normal output follows the live word one edge later
   p_normal_track_r6: assert property (@(posedge clk) disable iff (rst)
      (mode_d == MODE_NORMAL) |=> (freq_out == $past(freq_live)));
endmodule

// File: tb/dpll_mode_ctrl_tb.sv
module dpll_mode_ctrl_tb;
   localparam int FW = 32;
   localparam int PER = 32;
   localparam logic [FW-1:0] NOM = 32'h2000_0000;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [1:0]    mode_sel = 2'b00;
   logic          pri_lost = 1'b0, sec_lost = 1'b0;
   logic          freerun_req = 1'b0, ref_lock = 1'b0, tick_ms = 1'b0;
   logic [FW-1:0] freq_live = '0;
   logic [FW-1:0] freq_out;
   logic [1:0]    mode_state;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";

   // reference model state
   logic [1:0]    m_mode;
   logic [FW-1:0] m_freq;
   logic [FW-1:0] m_slot [2];
   logic          m_ptr;
   int            m_cnt, m_fill;

   always #2 clk = ~clk;

   dpll_mode_ctrl #(.FREQ_W(FW), .PERIOD_MS(PER), .NOMINAL_WORD(NOM)) u_dut (
      .clk(clk), .rst(rst), .mode_sel(mode_sel), .pri_lost(pri_lost),
      .sec_lost(sec_lost), .freerun_req(freerun_req), .ref_lock(ref_lock),
      .tick_ms(tick_ms), .freq_live(freq_live), .freq_out(freq_out),
      .mode_state(mode_state)
   );

   function automatic logic [1:0] next_mode(logic [1:0] cur);
      logic hc;
      hc = ((mode_sel == 2'b00) || (mode_sel == 2'b01)) && pri_lost && sec_lost;
      case (cur)
         2'b00:   return hc ? 2'b01 : 2'b00;
         2'b01:   return freerun_req ? 2'b10 : (hc ? 2'b01 : 2'b00);
         default: return (!freerun_req && !hc) ? 2'b00 : 2'b10;
      endcase
   endfunction

   task automatic model_edge();
      logic [1:0] nx;
      logic       st;
      if (rst) begin
         m_mode = 2'b10; m_freq = NOM; m_ptr = 1'b0; m_cnt = 0; m_fill = 0;
         m_slot[0] = '0; m_slot[1] = '0;
         return;
      end
      nx = next_mode(m_mode);
      st = (m_mode == 2'b00) && (nx == 2'b00) && ref_lock;
      if (nx == 2'b00)                         m_freq = freq_live;
      else if (nx == 2'b01 && m_mode != 2'b01) m_freq = (m_fill == 2) ? m_slot[m_ptr] : NOM;
      else if (nx == 2'b10)                    m_freq = NOM;
      if (!st) m_cnt = 0;
      else if (tick_ms) begin
         if (m_cnt == PER - 1) begin
            m_slot[m_ptr] = freq_live; m_ptr = ~m_ptr; m_cnt = 0;
            if (m_fill < 2) m_fill++;
         end else m_cnt++;
      end
      m_mode = nx;
   endtask

   task automatic check(string tag, string what, logic [FW-1:0] act, logic [FW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string freq_tag();
      if (m_mode == 2'b00) return "R6";
      if (m_mode == 2'b10) return "R10";
      return (m_fill == 2) ? "R8" : "R9";
   endfunction

   task automatic step();
      @(posedge clk);
      model_edge();
      @(negedge clk);
      check(cur_tag, "mode", FW'(mode_state), FW'(m_mode));
      check(freq_tag(), "freq", freq_out, m_freq);
   endtask

   task automatic steps(int n, bit vary_live);
      for (int i = 0; i < n; i++) begin
         if (vary_live) freq_live = $urandom;
         step();
      end
   endtask

   initial begin
      #(4 * 150000);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      @(negedge clk);
      cur_tag = "R1";                       // reset state
      steps(3, 1'b0);
      rst = 1'b0; ref_lock = 1'b1;
      cur_tag = "R5";                       // leave Freerun for Normal
      steps(2, 1'b1);
      cur_tag = "R9";                       // Holdover with no snapshots yet
      mode_sel = 2'b01; pri_lost = 1'b1; sec_lost = 1'b1;
      steps(4, 1'b1);
      pri_lost = 1'b0; sec_lost = 1'b0;
      cur_tag = "R7";                       // snapshots, with a lock drop inside
      tick_ms = 1'b1;
      steps(40, 1'b1);
      ref_lock = 1'b0; steps(5, 1'b1);
      ref_lock = 1'b1; steps(80, 1'b1);
      cur_tag = "R2";                       // manual Holdover uses older slot (R8)
      pri_lost = 1'b1; sec_lost = 1'b1;
      steps(10, 1'b1);
      cur_tag = "R4";                       // freerun pulse, then held in Freerun
      freerun_req = 1'b1; steps(1, 1'b1);
      freerun_req = 1'b0; steps(4, 1'b1);
      cur_tag = "R10";
      ref_lock = 1'b0; steps(3, 1'b1);
      ref_lock = 1'b1;
      cur_tag = "R5";
      pri_lost = 1'b0; sec_lost = 1'b0; steps(70, 1'b1);
      cur_tag = "R4";                       // freerun request ignored in Normal
      freerun_req = 1'b1; steps(3, 1'b1); freerun_req = 1'b0;
      cur_tag = "R3";                       // auto select, then blocked selects
      mode_sel = 2'b00; pri_lost = 1'b1; sec_lost = 1'b1; steps(5, 1'b1);
      pri_lost = 1'b0; sec_lost = 1'b0; steps(2, 1'b1);
      mode_sel = 2'b10; pri_lost = 1'b1; sec_lost = 1'b1; steps(3, 1'b1);
      mode_sel = 2'b11; steps(3, 1'b1);
      mode_sel = 2'b01; sec_lost = 1'b0; steps(3, 1'b1);
      pri_lost = 1'b0;
      cur_tag = "R7";                       // constrained random mix
      begin
         bit outage = 1'b0;
         for (int i = 0; i < 6000; i++) begin
            if (($urandom % 100) < 2) outage = ~outage;
            pri_lost    = outage || (($urandom % 20) == 0);
            sec_lost    = outage || (($urandom % 20) == 0);
            mode_sel    = (($urandom % 8) == 0) ? 2'($urandom) : 2'b01;
            freerun_req = (($urandom % 40) == 0);
            ref_lock    = (($urandom % 30) != 0);
            tick_ms     = (($urandom % 3) != 0);
            freq_live   = $urandom;
            step();
         end
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule